// File: doc/BRIEF.md
# Delayed power-good signal generator

This block drives the power-good indication of a multi-rail supply. It watches an auxiliary good flag, three rail-healthy flags (each high while its rail sits above its under-voltage level) and the shutdown/fault line of the neighbouring fault controller. All five flags pass through a synchronizer first. Power-good rises only after every condition has stayed good without a break for a long qualification delay, nominally 300 ms. It falls as soon as any synchronized condition is lost.

The delay is a tick count driven by a prescaler. The same tick period is used by the fault controller. Any lost condition clears the prescaler and the tick count, so an interrupted qualification always starts again from zero. A high output means the supply is healthy. A low output means it is off or faulted.

Top module: `pg_delay_gen`

## Requirements
- R1: While reset is active, `pg_o` is low. Reset clears the delay. After reset is released with all conditions good, `pg_o` stays low for SYNC_STAGES + TICK_DIV*DELAY_TICKS - 1 cycles and is high after SYNC_STAGES + TICK_DIV*DELAY_TICKS cycles.
- R2: All conditions good means `aux_good_i`=1, every bit of `rail_good_i`=1 and `fault_off_i`=0. When all conditions go good together, `pg_o` is still low SYNC_STAGES + TICK_DIV*DELAY_TICKS - 1 rising edges later and high one edge after that.
- R3: If any one of `aux_good_i`, `rail_good_i[0]`, `rail_good_i[1]` or `rail_good_i[2]` is held low, `pg_o` stays low however long the other conditions stay good.
- R4: When `pg_o` is high and `aux_good_i` or any rail bit drops, `pg_o` is low after SYNC_STAGES edges. It is still high after SYNC_STAGES - 1 edges. The drop does not wait on any delay.
- R5: A loss of any condition restarts the delay from zero. After the conditions return, the full SYNC_STAGES + TICK_DIV*DELAY_TICKS cycles are needed again, whatever part of the delay had already elapsed.
- R6: `fault_off_i`=1 forces `pg_o` low with the same latency as R4. While it is held high, `pg_o` never rises.
- R7: Once high, `pg_o` stays high for as long as all conditions remain good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| aux_good_i | input | 1 | Auxiliary input above its threshold (asynchronous) |
| rail_good_i | input | 3 | Rail above its under-voltage level, one bit per rail (asynchronous) |
| fault_off_i | input | 1 | Shutdown or latched fault from the fault controller, high = off (asynchronous) |
| pg_o | output | 1 | Power-good, high = supply healthy |

## Verification
The bench builds the block with SYNC_STAGES=2, TICK_DIV=4 and DELAY_TICKS=5, so a full qualification lasts 22 cycles. With these values every rise can be checked on both sides of its exact edge. The drop latency and the restart of a partial delay can be checked many times within a short run. A TICK_DIV above one also makes the prescaler wrap and the final-tick boundary part of each check.

// File: rtl/pg_pkg.sv
package pg_pkg;
    parameter int unsigned RAIL_COUNT = 3;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pg_delay_timer.sv
module pg_delay_timer #(
    parameter int unsigned TICK_DIV    = 250000,
    parameter int unsigned DELAY_TICKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned PRESC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int unsigned TICK_W  = $clog2(DELAY_TICKS + 1);
    localparam logic [PRESC_W-1:0] LAST_P = PRESC_W'(TICK_DIV - 1);
    localparam logic [TICK_W-1:0]  LAST_T = TICK_W'(DELAY_TICKS - 1);

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [TICK_W-1:0]  ticks;
        logic               done;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = '0;
        end else if (!st_q.done) begin
            if (st_q.presc == LAST_P) begin
                st_d.presc = '0;
                st_d.ticks = st_q.ticks + TICK_W'(1);
                if (st_q.ticks == LAST_T) st_d.done = 1'b1;
            end else begin
                st_d.presc = st_q.presc + PRESC_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;

    // R5
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.ticks == '0 && st_q.presc == '0 && !done_o));

    // R2
    tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ticks <= TICK_W'(DELAY_TICKS));

    // R2
    done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> st_q.ticks == TICK_W'(DELAY_TICKS));
endmodule

// File: rtl/pg_delay_gen.sv
module pg_delay_gen #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TICK_DIV    = 250000,
    parameter int unsigned DELAY_TICKS = 300
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          aux_good_i,
    input  logic [pg_pkg::RAIL_COUNT-1:0] rail_good_i,
    input  logic                          fault_off_i,
    output logic                          pg_o
);
    localparam int unsigned FLAGS = pg_pkg::RAIL_COUNT + 2;

    logic [FLAGS-1:0] flags_async, flags_sync;
    logic             aux_s, fault_s, all_ok, timer_done;
    logic [pg_pkg::RAIL_COUNT-1:0] rails_s;

    assign flags_async = {fault_off_i, aux_good_i, rail_good_i};

    pg_sync #(.WIDTH(FLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (flags_async),
        .sync_o  (flags_sync)
    );

    assign rails_s = flags_sync[pg_pkg::RAIL_COUNT-1:0];
    assign aux_s   = flags_sync[pg_pkg::RAIL_COUNT];
    assign fault_s = flags_sync[pg_pkg::RAIL_COUNT+1];
    assign all_ok  = aux_s & (&rails_s) & ~fault_s;

    pg_delay_timer #(.TICK_DIV(TICK_DIV), .DELAY_TICKS(DELAY_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (all_ok),
        .done_o (timer_done)
    );

    assign pg_o = timer_done & all_ok;

    // R6
    pg_low_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_s |-> !pg_o);

    // R4
    immediate_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(all_ok) |-> !pg_o);

    // R2
    rise_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_o) |-> $past(all_ok));

    // R7
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_o && all_ok) |=> pg_o || !all_ok);
endmodule

// File: tb/tb_pg_delay_gen.sv
`timescale 1ns/1ps
module tb_pg_delay_gen;
    localparam int SYNC = 2;
    localparam int DIV  = 4;
    localparam int DLY  = 5;
    localparam int LAT  = SYNC + DIV * DLY;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       aux = 1'b0;
    logic [2:0] rails = 3'b000;
    logic       fault = 1'b1;
    logic       pg;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pg_delay_gen #(.SYNC_STAGES(SYNC), .TICK_DIV(DIV), .DELAY_TICKS(DLY)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .aux_good_i  (aux),
        .rail_good_i (rails),
        .fault_off_i (fault),
        .pg_o        (pg)
    );

    task automatic check(input logic exp, input string req, input string what);
        checks++;
        if (pg !== exp) begin
            errors++;
            $display("FAIL %s %s: pg_o actual=%b expected=%b", req, what, pg, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // idx 0..2 rail bit, 3 aux, 4 fault; good=1 means the condition is good
    task automatic set_cond(input int idx, input logic good);
        if (idx < 3)       rails[idx] = good;
        else if (idx == 3) aux = good;
        else               fault = ~good;
    endtask

    task automatic all_good();
        aux = 1'b1; rails = 3'b111; fault = 1'b0;
    endtask

    task automatic all_bad();
        aux = 1'b0; rails = 3'b000; fault = 1'b1;
    endtask

    task automatic t_reset();
        all_good();
        wait_n(3);
        check(1'b0, "R1", "during reset");
        rst_n = 1'b1;
        wait_n(LAT - 1);
        check(1'b0, "R1", "one cycle before delay after reset");
        wait_n(1);
        check(1'b1, "R1", "delay complete after reset");
        rst_n = 1'b0;
        wait_n(1);
        check(1'b0, "R1", "reset forces low");
        rst_n = 1'b1;
        wait_n(LAT - 1);
        check(1'b0, "R1", "counter cleared by reset");
        wait_n(1);
        check(1'b1, "R1", "rise after second reset");
    endtask

    task automatic t_rise_hold();
        all_bad();
        wait_n(LAT + 2);
        check(1'b0, "R2", "all bad");
        all_good();
        wait_n(LAT - 1);
        check(1'b0, "R2", "one cycle early");
        wait_n(1);
        check(1'b1, "R2", "exact rise");
        for (int i = 0; i < 60; i++) begin
            wait_n(1);
            check(1'b1, "R7", "held high");
        end
    endtask

    task automatic t_missing(input int idx);
        all_bad();
        wait_n(LAT);
        all_good();
        set_cond(idx, 1'b0);
        for (int i = 0; i < 3; i++) begin
            wait_n(LAT);
            check(1'b0, (idx == 4) ? "R6" : "R3", "one condition missing");
        end
    endtask

    task automatic t_drop(input int idx);
        all_good();
        wait_n(LAT + 3);
        check(1'b1, "R4", "high before drop");
        set_cond(idx, 1'b0);
        wait_n(SYNC - 1);
        check(1'b1, (idx == 4) ? "R6" : "R4", "before drop latency");
        wait_n(1);
        check(1'b0, (idx == 4) ? "R6" : "R4", "dropped at latency");
        set_cond(idx, 1'b1);
        wait_n(LAT);
        check(1'b1, "R7", "recovered");
    endtask

    task automatic t_restart(input int partial);
        all_bad();
        wait_n(LAT);
        all_good();
        wait_n(partial);
        aux = 1'b0;
        wait_n(3);
        aux = 1'b1;
        wait_n(LAT - 1);
        check(1'b0, "R5", "partial delay not resumed");
        wait_n(1);
        check(1'b1, "R5", "full delay after restart");
    endtask

    initial begin
        wait_n(1);
        t_reset();
        t_rise_hold();
        for (int k = 0; k < 5; k++) t_missing(k);
        for (int k = 0; k < 5; k++) t_drop(k);
        t_restart(10);
        t_restart(LAT - 2);
        t_restart(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule